// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 32 level-sensitive interrupt request lines and drives one master interrupt output toward a processor. Software reaches it over a simple 32-bit register bus. The bus gives access to a control word, the raw request status, enable masks that are set and cleared one bit at a time, the vector of the request in service, a software request trigger, an end-of-service strobe, and a writable table with one vector word for each line.

When the controller is enabled and idle, it latches the lowest-numbered line that is both pending and enabled. It then asserts the master output and presents that line's table word. It keeps this selection, regardless of later input activity, until software writes the end-of-service register. The master output can be a level, or a pulse of programmable length that stands in for an edge. Its active sense can be inverted.

Top module: `vic_ctrl`

## Requirements
- R1: After reset, the control word and the enable mask read 0, no line is in service, the vector register reads 0 and the master output is low.
- R2: A write to offset 0x08 sets the enable bits that are one in the written data. A write to 0x0C clears the enable bits that are one. Zero bits leave their lines unchanged. The mask reads back at 0x10.
- R3: Offset 0x04 returns the unmasked request lines, with bit 0 also ORed with the software request flag. It does not depend on the enable mask or on the control word.
- R4: The control word at 0x00 has bit 0 = enable, bit 1 = invert, bit 2 = pulse mode and bits 23:8 = pulse length. While enable is 0, no new selection is made and the master output equals the invert bit.
- R5: When the controller is idle and enabled, it selects the lowest index among the lines that are pending and enabled. The request must be present on a clock edge, and the selection takes effect at that edge.
- R6: While a line is in service, offset 0x14 returns that line's table word. The word holds when the line drops or when a lower-numbered line rises. When no line is in service, 0x14 reads 0.
- R7: A write of any data to 0x1C ends the service of the current line. The next selection can happen at the following clock edge at the earliest.
- R8: In level mode (bit 2 = 0), the master output is active while a line is in service. Active means high, or low when invert is 1.
- R9: In pulse mode, each new selection produces one active pulse of exactly the programmed number of cycles, starting in the cycle the selection appears. A length of 250 is supported, and a length of 0 gives no pulse.
- R10: Table words live at 0x80 + 4*line. Each is readable and writable as a full 32-bit word.
- R11: A write to 0x18 raises a software request on line 0. The request is cleared when service of line 0 ends.
- R12: Reads of the write-only offsets 0x08, 0x0C, 0x18 and 0x1C, and of the unused range 0x20 to 0x7C, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Level-sensitive request lines |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| irq_o | output | 1 | Master interrupt output |

## Verification
The end-of-service write and the arrival of a new request can fall on the same clock edge. The bench provokes this by writing end-of-service for line 5 while raising line 3 at that edge, with line 5 still pending. It judges the result by requiring line 3's table word one edge later, which shows that the release comes first and the fresh arbitration then sees both lines. Random rounds with changing masks and line patterns compare the selected vector with a lowest-index model computed in the bench.

// File: rtl/vic_pkg.sv
package vic_pkg;
  // Word offsets (byte offset / 4) of the register file.
  localparam int W_CTRL = 0;
  localparam int W_RAW  = 1;
  localparam int W_ENS  = 2;
  localparam int W_ENC  = 3;
  localparam int W_ENR  = 4;
  localparam int W_VEC  = 5;
  localparam int W_SWI  = 6;
  localparam int W_EOI  = 7;
  localparam int W_TAB  = 32;
  // Control word layout.
  localparam int C_EN   = 0;
  localparam int C_INV  = 1;
  localparam int C_EDGE = 2;
  localparam int C_LEN  = 8;
endpackage

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int N     = 32,
  localparam int IW   = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vic_vtable.sv
module vic_vtable #(
  parameter int N   = 32,
  parameter int DW  = 32,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ridx_a,
  output logic [DW-1:0] rdata_a,
  input  logic [IW-1:0] ridx_b,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  assign rdata_a = mem[ridx_a];
  assign rdata_b = mem[ridx_b];
endmodule

// File: rtl/vic_pulse.sv
module vic_pulse #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lvl,
  input  logic [LW-1:0] len,
  output logic          active
);
  logic          lvl_q;
  logic [LW-1:0] cnt_q, cnt_d;
  logic          rise;

  assign rise = lvl & ~lvl_q;

  always_comb begin
    cnt_d = cnt_q;
    if (rise)              cnt_d = (len == '0) ? '0 : len - LW'(1);
    else if (cnt_q != '0)  cnt_d = cnt_q - LW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      lvl_q <= lvl;
      cnt_q <= cnt_d;
    end
  end

  assign active = (rise & (len != '0)) | (cnt_q != '0);
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl #(
  parameter int N_LINES = 32,
  parameter int LEN_W   = 16,
  parameter int ADDR_W  = 8,
  localparam int DW     = 32,
  localparam int IW     = $clog2(N_LINES),
  localparam int WW     = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_LINES-1:0] irq_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq_o
);
  import vic_pkg::*;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  // Address decode.
  logic [WW-1:0] word, tab_off;
  logic          tab_hit;
  logic [IW-1:0] tab_idx;
  assign word    = bus_addr[ADDR_W-1:2];
  assign tab_off = word - WW'(W_TAB);
  assign tab_hit = (word >= WW'(W_TAB)) && (tab_off < WW'(N_LINES));
  assign tab_idx = tab_off[IW-1:0];

  logic wr_ctrl, wr_ens, wr_enc, wr_swi, wr_eoi, wr_tab;
  assign wr_ctrl = bus_wr && (word == WW'(W_CTRL));
  assign wr_ens  = bus_wr && (word == WW'(W_ENS));
  assign wr_enc  = bus_wr && (word == WW'(W_ENC));
  assign wr_swi  = bus_wr && (word == WW'(W_SWI));
  assign wr_eoi  = bus_wr && (word == WW'(W_EOI));
  assign wr_tab  = bus_wr && tab_hit;

  // State.
  logic               ctrl_en, ctrl_inv, ctrl_edge;
  logic [LEN_W-1:0]   ctrl_len;
  logic [N_LINES-1:0] en_q, en_d;
  logic               swi_q, swi_d;
  logic               busy_q, busy_d;
  logic [IW-1:0]      cur_q, cur_d;

  logic [N_LINES-1:0] pend, cand;
  logic               found;
  logic [IW-1:0]      sel_idx;

  assign pend = irq_in | {{(N_LINES-1){1'b0}}, swi_q};
  assign cand = pend & en_q;

  vic_prio #(.N(N_LINES)) u_prio (
    .req (cand),
    .any (found),
    .idx (sel_idx)
  );

  // Next state.
  always_comb begin
    en_d   = en_q;
    swi_d  = swi_q;
    busy_d = busy_q;
    cur_d  = cur_q;
    if (wr_ens) en_d = en_q | bus_wdata[N_LINES-1:0];
    if (wr_enc) en_d = en_q & ~bus_wdata[N_LINES-1:0];
    if (wr_swi) swi_d = 1'b1;
    else if (busy_q && wr_eoi && (cur_q == '0)) swi_d = 1'b0;
    if (busy_q) begin
      if (wr_eoi) busy_d = 1'b0;
    end else if (ctrl_en && found) begin
      busy_d = 1'b1;
      cur_d  = sel_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctrl_en   <= 1'b0;
      ctrl_inv  <= 1'b0;
      ctrl_edge <= 1'b0;
      ctrl_len  <= '0;
    end else if (wr_ctrl) begin
      ctrl_en   <= bus_wdata[C_EN];
      ctrl_inv  <= bus_wdata[C_INV];
      ctrl_edge <= bus_wdata[C_EDGE];
      ctrl_len  <= bus_wdata[C_LEN +: LEN_W];
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      en_q   <= '0;
      swi_q  <= 1'b0;
      busy_q <= 1'b0;
      cur_q  <= '0;
    end else begin
      en_q   <= en_d;
      swi_q  <= swi_d;
      busy_q <= busy_d;
      cur_q  <= cur_d;
    end
  end

  // Vector table.
  logic [DW-1:0] tab_rd, vec_rd;
  vic_vtable #(.N(N_LINES), .DW(DW)) u_tab (
    .clk     (clk),
    .we      (wr_tab),
    .widx    (tab_idx),
    .wdata   (bus_wdata),
    .ridx_a  (tab_idx),
    .rdata_a (tab_rd),
    .ridx_b  (cur_q),
    .rdata_b (vec_rd)
  );

  // Output shaping.
  logic pulse_act, act;
  vic_pulse #(.LW(LEN_W)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .lvl    (busy_q),
    .len    (ctrl_len),
    .active (pulse_act)
  );

  assign act   = ctrl_en & (ctrl_edge ? pulse_act : busy_q);
  assign irq_o = act ^ ctrl_inv;

  // Read mux.
  always_comb begin
    bus_rdata = '0;
    if (tab_hit) begin
      bus_rdata = tab_rd;
    end else begin
      case (word)
        WW'(W_CTRL): begin
          bus_rdata[C_EN]             = ctrl_en;
          bus_rdata[C_INV]            = ctrl_inv;
          bus_rdata[C_EDGE]           = ctrl_edge;
          bus_rdata[C_LEN +: LEN_W]   = ctrl_len;
        end
        WW'(W_RAW): bus_rdata = DW'(pend);
        WW'(W_ENR): bus_rdata = DW'(en_q);
        WW'(W_VEC): bus_rdata = busy_q ? vec_rd : '0;
        default:    bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/vic_ctrl_chk.sv
module vic_ctrl_chk #(
  parameter int N_LINES = 32,
  parameter int ADDR_W  = 8,
  localparam int IW     = $clog2(N_LINES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_wr,
  input logic               busy_q,
  input logic [IW-1:0]      cur_q,
  input logic [N_LINES-1:0] en_q,
  input logic               ctrl_en,
  input logic               ctrl_inv,
  input logic               irq_o
);
  logic eoi_hit;
  assign eoi_hit = bus_wr && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(vic_pkg::W_EOI));

  // R6: selection holds until end-of-service
  p_hold_vector_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !eoi_hit) |=> (busy_q && $stable(cur_q)));

  // R7: end-of-service releases and leaves one idle cycle
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && eoi_hit) |=> !busy_q);

  // R4: output parked at its inactive level while disabled
  p_quiet_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |-> (irq_o == ctrl_inv));

  // R5: a new selection only takes a line that was enabled
  p_pick_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> ((($past(en_q) >> cur_q) & N_LINES'(1)) != '0));

  // R4: no selection starts while disabled
  p_no_start_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !ctrl_en) |=> !busy_q);
endmodule

bind vic_ctrl vic_ctrl_chk #(.N_LINES(N_LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .busy_q   (busy_q),
  .cur_q    (cur_q),
  .en_q     (en_q),
  .ctrl_en  (ctrl_en),
  .ctrl_inv (ctrl_inv),
  .irq_o    (irq_o)
);

// File: tb/vic_ctrl_tb.sv
module vic_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] tab [32];

  always #2 clk = ~clk;  // 250 MHz

  vic_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] model_vec(input logic [31:0] lines, input logic [31:0] mask);
    logic [31:0] c = lines & mask;
    for (int i = 0; i < 32; i++) if (c[i]) return tab[i];
    return 32'h0;
  endfunction

  task automatic count_act(input int win, output int cnt);
    cnt = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      if (irq_o) cnt++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int cnt;
    void'($urandom(32'd4711));
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    rd(8'h00, d); chk("R1 ctrl", d, 0);
    rd(8'h10, d); chk("R1 mask", d, 0);
    rd(8'h14, d); chk("R1 vec", d, 0);
    chk("R1 irq_o", {31'b0, irq_o}, 0);

    // R10 table fill and readback
    for (int i = 0; i < 32; i++) begin
      tab[i] = $urandom;
      wr(8'h80 + 8'(4 * i), tab[i]);
    end
    for (int i = 0; i < 32; i += 7) begin
      rd(8'h80 + 8'(4 * i), d); chk("R10 table", d, tab[i]);
    end

    // R12 write-only and unused read zero
    rd(8'h08, d); chk("R12 ens", d, 0);
    rd(8'h0C, d); chk("R12 enc", d, 0);
    rd(8'h18, d); chk("R12 swi", d, 0);
    rd(8'h1C, d); chk("R12 eoi", d, 0);
    rd(8'h40, d); chk("R12 gap", d, 0);

    // R2 set/clear
    wr(8'h08, 32'h0000_F0F0);
    wr(8'h08, 32'h0000_0101);
    wr(8'h0C, 32'h0000_1010);
    rd(8'h10, d); chk("R2 mask", d, 32'h0000_E1E1);

    // R4 disabled: nothing happens
    irq_in = 32'h0000_0100;
    idle(3);
    chk("R4 off irq", {31'b0, irq_o}, 0);
    rd(8'h14, d); chk("R4 off vec", d, 0);
    wr(8'h00, 32'h2);  // invert only
    chk("R4 off inv", {31'b0, irq_o}, 1);

    // R5/R6/R8 random rounds
    for (int r = 0; r < 40; r++) begin
      logic [31:0] lines, mask;
      wr(8'h00, 32'h0);
      wr(8'h1C, 32'h0);
      lines = $urandom & $urandom;
      mask  = $urandom;
      if (r % 5 == 0) lines = 32'h0;
      irq_in = lines;
      wr(8'h0C, 32'hFFFF_FFFF);
      wr(8'h08, mask);
      wr(8'h00, 32'h1);
      idle(2);
      rd(8'h14, d); chk("R5 vec", d, model_vec(lines, mask));
      chk("R8 level", {31'b0, irq_o}, {31'b0, ((lines & mask) != 0)});
      rd(8'h04, d); chk("R3 raw", d, lines);
    end

    // R6 hold and R7 coincident end-of-service with new request
    wr(8'h00, 32'h0);
    wr(8'h1C, 32'h0);
    irq_in = 32'h0000_0020;
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h08, 32'h0000_0028);
    wr(8'h00, 32'h1);
    idle(2);
    rd(8'h14, d); chk("R5 line5", d, tab[5]);
    irq_in = 32'h0000_0028;
    idle(2);
    rd(8'h14, d); chk("R6 hold lower", d, tab[5]);
    irq_in = 32'h0000_0000;
    idle(2);
    rd(8'h14, d); chk("R6 hold drop", d, tab[5]);
    irq_in = 32'h0000_0020;
    @(negedge clk);
    bus_addr = 8'h1C; bus_wr = 1'b1; irq_in = 32'h0000_0028;
    @(negedge clk);
    bus_wr = 1'b0;
    #1 chk("R7 idle gap", {31'b0, irq_o}, 0);
    @(negedge clk);
    rd(8'h14, d); chk("R7 coincident", d, tab[3]);
    wr(8'h1C, 32'h0);
    irq_in = 32'h0;
    wr(8'h1C, 32'h0);
    idle(2);
    rd(8'h14, d); chk("R7 released", d, 0);

    // R11 software request
    wr(8'h00, 32'h0);
    wr(8'h18, 32'h1);
    rd(8'h04, d); chk("R11 raw", d, 32'h1);
    wr(8'h08, 32'h1);
    wr(8'h00, 32'h1);
    idle(2);
    rd(8'h14, d); chk("R11 vec", d, tab[0]);
    wr(8'h00, 32'h0);
    wr(8'h1C, 32'h0);
    rd(8'h04, d); chk("R11 cleared", d, 0);

    // R9 pulse mode
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h08, 32'h0000_0300);
    irq_in = 32'h0000_0300;
    wr(8'h00, (32'd7 << 8) | 32'h5);
    count_act(30, cnt); chk("R9 len7", cnt, 7);
    rd(8'h14, d); chk("R9 vec", d, tab[8]);
    irq_in = 32'h0000_0200;
    wr(8'h1C, 32'h0);
    count_act(30, cnt); chk("R9 reissue", cnt, 7);
    wr(8'h00, 32'h0);
    wr(8'h1C, 32'h0);
    wr(8'h00, (32'd250 << 8) | 32'h5);
    count_act(300, cnt); chk("R9 len250", cnt, 250);
    wr(8'h00, 32'h0);
    wr(8'h1C, 32'h0);
    wr(8'h00, 32'h5);
    count_act(20, cnt); chk("R9 len0", cnt, 0);
    rd(8'h00, d); chk("R4 ctrl read", d, 32'h5);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule